// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces a 10-bit successive-approximation conversion on a clock divided down from the CPU clock. A conversion begins in one of two ways. Software can pulse a start request. When auto-trigger is enabled, a rising edge on an external trigger line can also begin one. The block then runs the divided clock for thirteen conversion cycles. It strobes the sample-and-hold on the second cycle and makes one bit decision per cycle on cycles three through twelve, most significant bit first. It stores the result and raises a sticky completion flag at the end of cycle thirteen.

The comparator and DAC sit outside the block. The sequencer presents a trial code on `dac_code` and reads the comparator's verdict on `cmp_in`. Each conversion start clears the prescaler, so every conversion starts at a fixed phase. When free-running is selected, each conversion chains straight into the next. The channel and reference selects are captured at the sample point. The stored result is presented over two 8-bit registers, either right- or left-aligned.

Top module: `adc_conv_seq`

## Requirements
- R1: The divide ratio N is 2^sel for `prescale_sel` = 1..7 and 2 for sel = 0. After a `start_req` sampled at clock edge E while idle, `busy` is high from E. It falls, with the result stored, at edge E+13N.
- R2: `sh_strobe` is a single-cycle pulse, asserted after edge E+2N, where E is the conversion's start edge.
- R3: With `auto_en` high, a rising edge on `trig_in` that is set up before edge E0 starts a conversion at edge E0+3. The sample strobe follows at E0+3+2N and completion at E0+3+13N.
- R4: Each conversion gives exactly ten `step_strobe` pulses. Bit decisions run from MSB to LSB. A trial bit is kept when `cmp_in` is 1 at its decision edge, so with a comparator that reports vin >= dac_code, the result equals vin.
- R5: When `align_left` is 0, `res_hi` = {6'b0, res[9:8]} and `res_lo` = res[7:0]. When it is 1, `res_hi` = res[9:2] and `res_lo` = {res[1:0], 6'b0}.
- R6: `done_flag` sets at the completion edge and stays set until `flag_clr` is sampled high. A completion in the same cycle as a clear leaves it set. A completion while it is already set keeps it set and still updates the result.
- R7: With `free_run` high at completion, the next conversion starts at that same edge. `busy` stays high, and completions repeat every 13N cycles until `free_run` is low at a completion.
- R8: `start_req` and trigger edges that arrive while `busy` is high are ignored, and the running conversion's completion time does not change.
- R9: Trigger edges are ignored while `auto_en` is low. A trigger held high starts nothing further once its edge has been consumed.
- R10: `chan_q` and `ref_q` load `chan_sel` and `ref_sel` only at the sample strobe. Later changes show only at the next conversion.
- R11: After reset, `busy`, `done_flag`, `sh_strobe`, `step_strobe`, `res_hi`, `res_lo`, `chan_q` and `ref_q` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prescale_sel | input | 3 | Divide ratio select, N = 2^sel (0 gives 2) |
| start_req | input | 1 | Single-cycle software start request |
| auto_en | input | 1 | Enables starting on trigger edges |
| free_run | input | 1 | Chain conversions back to back |
| trig_in | input | 1 | Asynchronous trigger source |
| flag_clr | input | 1 | Write-one pulse clearing the completion flag |
| align_left | input | 1 | Result alignment select |
| chan_sel | input | 4 | Channel select, captured at sampling |
| ref_sel | input | 2 | Reference select, captured at sampling |
| cmp_in | input | 1 | Comparator verdict, 1 when input >= trial code |
| busy | output | 1 | Conversion in progress (start bit readback) |
| sh_strobe | output | 1 | Sample-and-hold pulse |
| step_strobe | output | 1 | Pulse after each bit decision |
| dac_code | output | 10 | Current trial code toward the DAC |
| done_flag | output | 1 | Sticky completion flag |
| res_hi | output | 8 | Upper result register |
| res_lo | output | 8 | Lower result register |
| chan_q | output | 4 | Channel used by the current sample |
| ref_q | output | 2 | Reference used by the current sample |

## Verification
The main function is exercised with software starts and with trigger edges, at every divide ratio including the sel = 0 fallback, with random analog values and with both alignments. Measuring the sample and completion edges separates an offset of three synchronizer cycles from a wrong divide ratio. A random analog value separates a correct MSB-first decision order from bit-order or keep/discard mistakes. A free-running chain, together with clear pulses placed mid-conversion and on the completion edge itself, separates "set wins" from "clear wins" and shows that the restart is back to back. Start and trigger pulses sent mid-conversion, a held trigger level, and trigger edges with auto-trigger off each show whether a spurious start would shift the completion edge or raise `busy`.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SH_CYC     = 2;
  localparam int FIRST_STEP = 3;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seq_state_t;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic auto_en,
  output logic fire
);
  logic s1_q, s2_q, s3_q, fire_q;
  logic fire_d;

  // edge detect on synchronized level
  always_comb fire_d = auto_en & s2_q & ~s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      s1_q   <= trig_in;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      fire_q <= fire_d;
    end
  end

  assign fire = fire_q;
endmodule

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int SEL_W = 3,
  localparam int CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             at_limit;

  always_comb begin
    if (sel == '0) limit = CNT_W'(1);
    else           limit = (CNT_W'(1) << sel) - CNT_W'(1);
  end

  always_comb begin
    at_limit = (cnt_q == limit);
    tick     = run & ~restart & at_limit;
    if (!run || restart || at_limit) cnt_d = '0;
    else                             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             go,
  input  logic             free_run,
  input  logic             cmp_in,
  output logic             busy,
  output logic             sh_evt,
  output logic             step_evt,
  output logic             done_evt,
  output logic [RES_W-1:0] result,
  output logic [RES_W-1:0] trial
);
  localparam int LAST_STEP = FIRST_STEP + RES_W - 1;
  localparam int CONV_CYC  = LAST_STEP + 1;
  localparam int CYC_W     = $clog2(CONV_CYC + 1);
  localparam logic [RES_W-1:0] MSB_MASK = {1'b1, {(RES_W-1){1'b0}}};

  seq_state_t       st_q, st_d;
  logic [CYC_W-1:0] cyc_q, cyc_d, cyc_nx;
  logic [RES_W-1:0] sar_q, sar_d, mask_q, mask_d, res_q, res_d;

  always_comb begin
    st_d     = st_q;
    cyc_d    = cyc_q;
    sar_d    = sar_q;
    mask_d   = mask_q;
    res_d    = res_q;
    sh_evt   = 1'b0;
    step_evt = 1'b0;
    done_evt = 1'b0;
    cyc_nx   = cyc_q + CYC_W'(1);
    if (st_q == SEQ_IDLE) begin
      if (go) begin
        st_d   = SEQ_CONV;
        cyc_d  = '0;
        sar_d  = '0;
        mask_d = MSB_MASK;
      end
    end else if (tick) begin
      cyc_d = cyc_nx;
      if (cyc_nx == CYC_W'(SH_CYC)) sh_evt = 1'b1;
      if (cyc_nx >= CYC_W'(FIRST_STEP) && cyc_nx <= CYC_W'(LAST_STEP)) begin
        step_evt = 1'b1;
        if (cmp_in) sar_d = sar_q | mask_q;
        mask_d = mask_q >> 1;
      end
      if (cyc_nx == CYC_W'(CONV_CYC)) begin
        done_evt = 1'b1;
        res_d    = sar_q;
        cyc_d    = '0;
        if (free_run) begin
          sar_d  = '0;
          mask_d = MSB_MASK;
        end else begin
          st_d = SEQ_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      cyc_q  <= '0;
      sar_q  <= '0;
      mask_q <= '0;
      res_q  <= '0;
    end else begin
      st_q   <= st_d;
      cyc_q  <= cyc_d;
      sar_q  <= sar_d;
      mask_q <= mask_d;
      res_q  <= res_d;
    end
  end

  assign busy   = (st_q == SEQ_CONV);
  assign result = res_q;
  assign trial  = sar_q | mask_q;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int RES_W  = 10,
  parameter int REG_W  = 8,
  parameter int SEL_W  = 3,
  parameter int CHAN_W = 4,
  parameter int REF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  prescale_sel,
  input  logic              start_req,
  input  logic              auto_en,
  input  logic              free_run,
  input  logic              trig_in,
  input  logic              flag_clr,
  input  logic              align_left,
  input  logic [CHAN_W-1:0] chan_sel,
  input  logic [REF_W-1:0]  ref_sel,
  input  logic              cmp_in,
  output logic              busy,
  output logic              sh_strobe,
  output logic              step_strobe,
  output logic [RES_W-1:0]  dac_code,
  output logic              done_flag,
  output logic [REG_W-1:0]  res_hi,
  output logic [REG_W-1:0]  res_lo,
  output logic [CHAN_W-1:0] chan_q,
  output logic [REF_W-1:0]  ref_q
);
  localparam int FULL_W = 2 * REG_W;
  localparam int PAD_W  = FULL_W - RES_W;

  logic rs1_q, rs2_q, rst_int_n;
  logic fire, go, tick, core_busy;
  logic sh_evt, step_evt, done_evt;
  logic [RES_W-1:0]  result;
  logic [FULL_W-1:0] right_v, left_v, view_v;
  logic              flag_q, flag_d, sh_q, step_q;
  logic [CHAN_W-1:0] chan_r, chan_d;
  logic [REF_W-1:0]  ref_r, ref_d;

  // reset: asserted at once, released on clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  adc_trig_sync u_trig (
    .clk(clk), .rst_n(rst_int_n), .trig_in(trig_in),
    .auto_en(auto_en), .fire(fire)
  );

  assign go = ~core_busy & (start_req | fire);

  adc_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst_n(rst_int_n), .run(core_busy),
    .restart(go), .sel(prescale_sel), .tick(tick)
  );

  adc_sar_core #(.RES_W(RES_W)) u_core (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .go(go),
    .free_run(free_run), .cmp_in(cmp_in), .busy(core_busy),
    .sh_evt(sh_evt), .step_evt(step_evt), .done_evt(done_evt),
    .result(result), .trial(dac_code)
  );

  always_comb begin
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (done_evt) flag_d = 1'b1;
    chan_d = sh_evt ? chan_sel : chan_r;
    ref_d  = sh_evt ? ref_sel  : ref_r;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      flag_q <= 1'b0;
      sh_q   <= 1'b0;
      step_q <= 1'b0;
      chan_r <= '0;
      ref_r  <= '0;
    end else begin
      flag_q <= flag_d;
      sh_q   <= sh_evt;
      step_q <= step_evt;
      chan_r <= chan_d;
      ref_r  <= ref_d;
    end
  end

  always_comb begin
    right_v = FULL_W'(result);
    left_v  = FULL_W'(result) << PAD_W;
    view_v  = align_left ? left_v : right_v;
  end

  assign busy        = core_busy;
  assign sh_strobe   = sh_q;
  assign step_strobe = step_q;
  assign done_flag   = flag_q;
  assign res_hi      = view_v[FULL_W-1:REG_W];
  assign res_lo      = view_v[REG_W-1:0];
  assign chan_q      = chan_r;
  assign ref_q       = ref_r;
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int CHAN_W = 4,
  parameter int REF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              sh_strobe,
  input logic              step_strobe,
  input logic              done_flag,
  input logic              flag_clr,
  input logic [CHAN_W-1:0] chan_q,
  input logic [REF_W-1:0]  ref_q
);
  p_sh_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sh_strobe |=> !sh_strobe);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sh_strobe, step_strobe}));

  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);

  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sh_strobe && !step_strobe));

  p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({chan_q, ref_q}) |-> sh_strobe);
endmodule

bind adc_conv_seq adc_conv_seq_chk #(.CHAN_W(CHAN_W), .REF_W(REF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sh_strobe(sh_strobe),
  .step_strobe(step_strobe), .done_flag(done_flag), .flag_clr(flag_clr),
  .chan_q(chan_q), .ref_q(ref_q)
);

// File: tb/sim_adc_conv_seq.sv
module sim_adc_conv_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] prescale_sel;
  logic start_req, auto_en, free_run, trig_in, flag_clr, align_left, cmp_in;
  logic [3:0] chan_sel;
  logic [1:0] ref_sel;
  logic busy, sh_strobe, step_strobe, done_flag;
  logic [9:0] dac_code, vin;
  logic [7:0] res_hi, res_lo;
  logic [3:0] chan_q;
  logic [1:0] ref_q;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // behavioural comparator stub
  assign cmp_in = (vin >= dac_code);

  adc_conv_seq u0 (
    .clk(clk), .rst_n(rst_n), .prescale_sel(prescale_sel), .start_req(start_req),
    .auto_en(auto_en), .free_run(free_run), .trig_in(trig_in), .flag_clr(flag_clr),
    .align_left(align_left), .chan_sel(chan_sel), .ref_sel(ref_sel), .cmp_in(cmp_in),
    .busy(busy), .sh_strobe(sh_strobe), .step_strobe(step_strobe), .dac_code(dac_code),
    .done_flag(done_flag), .res_hi(res_hi), .res_lo(res_lo), .chan_q(chan_q), .ref_q(ref_q)
  );

  function automatic int exp_ratio(input int sel);
    return (sel == 0) ? 2 : (1 << sel);
  endfunction

  function automatic logic [15:0] exp_regs(input logic [9:0] v, input bit left);
    return left ? {v, 6'b0} : {6'b0, v};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic conv_check(input int sel, input logic [9:0] v, input bit via_trig,
                            input bit left, input bit clr_first);
    int n, sh_at, steps, done_at, off, nr;
    bit low_seen;
    logic [3:0] c0;
    logic [1:0] r0;
    logic [15:0] er;
    if (clr_first) clear_flag();
    c0 = 4'($urandom_range(0, 15));
    r0 = 2'($urandom_range(0, 3));
    @(negedge clk);
    prescale_sel = 3'(sel); vin = v; align_left = left;
    chan_sel = c0; ref_sel = r0;
    if (via_trig) begin auto_en = 1'b1; trig_in = 1'b1; end
    else start_req = 1'b1;
    off = via_trig ? 4 : 1;
    nr = exp_ratio(sel);
    n = 0; sh_at = -1; steps = 0; done_at = -1; low_seen = 0;
    while (n < 20000) begin
      @(negedge clk); n++;
      start_req = 1'b0;
      if (!clr_first && !done_flag) low_seen = 1;
      if (sh_strobe) begin sh_at = n; chan_sel = ~c0; ref_sel = ~r0; end
      if (step_strobe) steps++;
      if (n > off && !busy) begin done_at = n; break; end
    end
    trig_in = 1'b0;
    er = exp_regs(v, left);
    chk(done_at == off + 13*nr, via_trig ? "R3 completion edge" : "R1 completion edge",
        done_at, off + 13*nr);
    chk(sh_at == off + 2*nr, "R2 sample strobe edge", sh_at, off + 2*nr);
    chk(steps == 10, "R4 step count", steps, 10);
    chk({res_hi, res_lo} == er, "R4 R5 result registers", {res_hi, res_lo}, er);
    chk(done_flag == 1'b1, "R6 flag after completion", done_flag, 1);
    chk(!low_seen, "R6 flag stays set across completion", low_seen, 0);
    chk({chan_q, ref_q} == {c0, r0}, "R10 captured selects", {chan_q, ref_q}, {c0, r0});
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    rst_n = 1'b0; prescale_sel = 3'd1; start_req = 0; auto_en = 0; free_run = 0;
    trig_in = 0; flag_clr = 0; align_left = 0; chan_sel = 0; ref_sel = 0; vin = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({busy, done_flag, sh_strobe, step_strobe} == 0, "R11 control outputs in reset",
        {busy, done_flag, sh_strobe, step_strobe}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({res_hi, res_lo, chan_q, ref_q} == 0, "R11 data outputs after reset",
        {res_hi, res_lo, chan_q, ref_q}, 0);

    // directed ratios including fallback and the slowest
    conv_check(0, 10'h2AA, 0, 0, 1);
    conv_check(7, 10'h155, 0, 1, 1);
    conv_check(3, 10'h3FF, 1, 0, 1);
    conv_check(1, 10'h000, 1, 1, 1);
    // R6: second completion with flag left set updates result
    conv_check(2, 10'd513, 0, 0, 0);

    // constrained random
    for (int i = 0; i < 10; i++)
      conv_check($urandom_range(1, 5), 10'($urandom_range(0, 1023)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1);

    // R7 free-running chain with R6 clear timing
    clear_flag();
    @(negedge clk);
    prescale_sel = 3'd1; vin = 10'd300; align_left = 0; free_run = 1; start_req = 1;
    for (int n = 1; n <= 90; n++) begin
      @(negedge clk);
      start_req = 0;
      if (n == 27) begin
        chk(done_flag, "R7 first chained completion flag", done_flag, 1);
        chk(busy, "R7 busy held through chain", busy, 1);
        chk({res_hi, res_lo} == 16'd300, "R7 first result", {res_hi, res_lo}, 300);
      end
      if (n == 28) vin = 10'd777;
      if (n == 40) flag_clr = 1;
      if (n == 41) begin
        chk(!done_flag, "R6 clear pulse", done_flag, 0);
        flag_clr = 0;
      end
      if (n == 52) flag_clr = 1;
      if (n == 53) begin
        flag_clr = 0;
        chk(done_flag, "R6 set wins over clear", done_flag, 1);
        chk({res_hi, res_lo} == 16'd777, "R7 second result", {res_hi, res_lo}, 777);
      end
      if (n == 60) free_run = 0;
      if (n == 78) chk(busy, "R7 third conversion running", busy, 1);
      if (n == 79) chk(!busy, "R7 chain stops", busy, 0);
    end

    // R8 start and trigger while busy
    clear_flag();
    @(negedge clk);
    prescale_sel = 3'd2; vin = 10'd42; start_req = 1;
    for (int n = 1; n <= 53; n++) begin
      @(negedge clk);
      start_req = 0;
      if (n == 10) begin start_req = 1; auto_en = 1; trig_in = 1; end
      if (n == 52) chk(busy, "R8 busy before completion", busy, 1);
      if (n == 53) chk(!busy, "R8 completion unchanged", busy, 0);
    end
    // R9 held trigger level starts nothing
    repeat (40) @(negedge clk);
    chk(!busy, "R9 held trigger no restart", busy, 0);
    trig_in = 0;
    repeat (5) @(negedge clk);
    // R9 trigger edge with auto-trigger off
    auto_en = 0; trig_in = 1;
    repeat (40) @(negedge clk);
    chk(!busy, "R9 trigger ignored when disabled", busy, 0);
    trig_in = 0;

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule